// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Parallel Outputs

This block takes a serial bit stream on a shift clock, holds it in a chain of stages, and copies the whole chain into a separate storage register when a second clock rises. The parallel outputs come from the storage register, so they stay fixed while new data is shifted in behind them. An active-low enable lets the parallel outputs release their lines to high impedance, which allows them to share a bus.

The last shift stage is also brought out as a serial cascade output. It is always driven. Wiring that output to the serial input of a second instance, with both instances on the same clocks, builds a longer register. An active-low asynchronous reset clears the shift stages only. Its release is synchronised to the shift clock, so the first few shift edges after release are used up and shift nothing in. The stage count and the synchroniser depth are parameters.

Top module: `serial_latch_shifter`

## Requirements
- R1: On each enabled rising edge of `shift_clk`, `ser_in` is captured into stage 0, and every stage k moves to stage k+1.
- R2: On a rising edge of `store_clk`, all stages are copied into the storage register in a single step. Without a `store_clk` edge the storage register keeps its value, even while shifting continues.
- R3: While `rst_n` is low, every shift stage is zero, so `ser_out` is 0. The storage register is not changed by reset.
- R4: After `rst_n` rises, the first RST_SYNC_STAGES rising edges of `shift_clk` (default 2) leave all stages unchanged. Shifting starts on the next edge.
- R5: When `oe_n` is 1, all bits of `par_out` are high impedance. When `oe_n` is 0, `par_out` shows the storage register.
- R6: `ser_out` always equals the last stage (index WIDTH-1), whatever the value of `oe_n`.
- R7: When `shift_clk` and `store_clk` rise together, the storage register receives the stage contents from before that shift.
- R8: When the `ser_out` of one instance drives the `ser_in` of a second instance on shared clocks, the two behave as one 2*WIDTH-stage register. After 2*WIDTH shifts, the first instance holds the newest WIDTH bits and the second holds the older WIDTH bits.
- R9: `par_out[0]` is stage 0, which holds the most recently shifted bit, and `par_out[WIDTH-1]` is the last stage. For example, shifting 1 followed by seven 0s and then storing gives 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift clock; rising edge advances the chain |
| rst_n | input | 1 | Active-low asynchronous clear of the shift stages |
| store_clk | input | 1 | Storage clock; rising edge copies the stages |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| par_out | output | WIDTH | Parallel outputs from the storage register, tri-stateable |
| ser_out | output | 1 | Cascade output, last shift stage |

## Verification
The hardest cases to reach from the ports are a shift edge and a store edge arriving on the same clock instant, and the bus release under `oe_n`. A released bus cannot be seen unless something else drives the line. The stimulus raises both clocks in the same timestep, both in directed steps and within a random mix, and checks that storage lags the chain by one stage. While `oe_n` is high, the bench drives its own pattern onto the shared `par_out` net and expects to read that pattern back. A second instance chained from `ser_out` shows the combined 16-stage behaviour. The edges that the reset synchroniser consumes are checked by shifting ones just after reset release.

// File: rtl/slat_pkg.sv
package slat_pkg;
  localparam int SLAT_WIDTH_DEF = 8;
  localparam int SLAT_SYNC_DEF  = 2;

  // drive state of the parallel pins, indexed by the oe_n level
  typedef enum logic {
    PAR_DRIVE = 1'b0,
    PAR_FLOAT = 1'b1
  } par_mode_e;
endpackage

// File: rtl/slat_rst_sync.sv
module slat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic shift_clk,
  input  logic rst_n,
  output logic run_en
);
  generate
    if (STAGES == 0) begin : g_direct
      assign run_en = rst_n;
    end else begin : g_sync
      logic [STAGES-1:0] sync_q;
      logic [STAGES-1:0] sync_d;

      always_comb begin
        sync_d    = sync_q << 1;
        sync_d[0] = 1'b1;
      end

      always_ff @(posedge shift_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
      end

      assign run_en = sync_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/slat_shift_chain.sv
module slat_shift_chain #(
  parameter int WIDTH = 8
) (
  input  logic             shift_clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages
);
  // next chain value: new bit at index 0, everything moves one place up
  function automatic logic [WIDTH-1:0] shift_feed(input logic [WIDTH-1:0] cur,
                                                  input logic din);
    return {cur[WIDTH-2:0], din};
  endfunction

  logic [WIDTH-1:0] feed;
  assign feed = shift_feed(stages, ser_in);

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    always_ff @(posedge shift_clk or negedge rst_n) begin
      if (!rst_n)      stages[k] <= 1'b0;
      else if (run_en) stages[k] <= feed[k];
    end
  end

  AST_HEAD_CAPTURE: assert property (@(posedge shift_clk) disable iff (!rst_n)
    run_en |=> stages[0] == $past(ser_in)); // R1

  for (genvar k = 1; k < WIDTH; k++) begin : g_adv_chk
    AST_STAGE_ADVANCE: assert property (@(posedge shift_clk) disable iff (!rst_n)
      run_en |=> stages[k] == $past(stages[k-1])); // R1
  end

  AST_HOLD_WHILE_SYNC: assert property (@(posedge shift_clk) disable iff (!rst_n)
    !run_en |=> $stable(stages)); // R4
endmodule

// File: rtl/slat_store_reg.sv
module slat_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             store_clk,
  input  logic [WIDTH-1:0] shift_q,
  output logic [WIDTH-1:0] store_q
);
  // no reset: contents are undefined until the first store edge
  always_ff @(posedge store_clk) begin
    store_q <= shift_q;
  end
endmodule

// File: rtl/slat_par_drive.sv
module slat_par_drive #(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] store_q,
  output wire  [WIDTH-1:0] par_out
);
  import slat_pkg::*;

  par_mode_e mode;
  assign mode    = par_mode_e'(oe_n);
  assign par_out = (mode == PAR_FLOAT) ? {WIDTH{1'bz}} : store_q;
endmodule

// File: rtl/serial_latch_shifter.sv
module serial_latch_shifter #(
  parameter int WIDTH          = slat_pkg::SLAT_WIDTH_DEF,
  parameter int RST_SYNC_STAGES = slat_pkg::SLAT_SYNC_DEF
) (
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             rst_n,
  input  logic             store_clk,
  input  logic             oe_n,
  output wire  [WIDTH-1:0] par_out,
  output logic             ser_out
);
  localparam int LAST = WIDTH - 1;

  logic             run_en;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] store_q;

  slat_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_sync (
    .shift_clk (shift_clk),
    .rst_n     (rst_n),
    .run_en    (run_en)
  );

  slat_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .shift_clk (shift_clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .ser_in    (ser_in),
    .stages    (shift_q)
  );

  slat_store_reg #(.WIDTH(WIDTH)) u_store (
    .store_clk (store_clk),
    .shift_q   (shift_q),
    .store_q   (store_q)
  );

  slat_par_drive #(.WIDTH(WIDTH)) u_drive (
    .oe_n    (oe_n),
    .store_q (store_q),
    .par_out (par_out)
  );

  assign ser_out = shift_q[LAST];

  AST_STORE_CAPTURE: assert property (@(posedge store_clk) disable iff (!rst_n)
    rst_n |=> store_q == $past(shift_q)); // R2

  AST_PAR_SHOWS_STORE: assert property (@(posedge store_clk) disable iff (!rst_n)
    !oe_n |-> par_out == store_q); // R5
endmodule

// File: tb/serial_latch_shifter_test.sv
module serial_latch_shifter_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic ser_in = 1'b0, shift_clk = 1'b0, rst_n = 1'b0, store_clk = 1'b0, oe_n = 1'b1;
  logic [7:0] tb_drv = 8'h00;
  wire  [7:0] par_bus;
  wire        ser_out;
  wire  [7:0] par_b;
  wire        ser_out_b;

  assign par_bus = oe_n ? tb_drv : 8'bz;

  serial_latch_shifter uut (
    .ser_in(ser_in), .shift_clk(shift_clk), .rst_n(rst_n), .store_clk(store_clk),
    .oe_n(oe_n), .par_out(par_bus), .ser_out(ser_out));

  serial_latch_shifter chain_b (
    .ser_in(ser_out), .shift_clk(shift_clk), .rst_n(rst_n), .store_clk(store_clk),
    .oe_n(1'b0), .par_out(par_b), .ser_out(ser_out_b));

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] m16 = 16'h0;
  logic [7:0]  st_a = 8'h0, st_b = 8'h0;
  bit st_valid = 0;
  int skip = 0;

  function automatic logic [15:0] model_shift(input logic [15:0] m, input logic d);
    return {m[14:0], d};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit sh, input bit st, input bit d);
    @(negedge clk); ser_in = d;
    @(posedge clk); shift_clk = sh; store_clk = st;
    if (st) begin st_a = m16[7:0]; st_b = m16[15:8]; st_valid = 1; end
    if (sh && rst_n) begin
      if (skip > 0) skip--;
      else m16 = model_shift(m16, d);
    end
    @(negedge clk); shift_clk = 0; store_clk = 0;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check({req, " ser_out"}, {15'h0, ser_out}, {15'h0, m16[7]});
    check({req, " ser_out_b"}, {15'h0, ser_out_b}, {15'h0, m16[15]});
    if (st_valid) begin
      if (!oe_n) check({req, " par"}, {8'h0, par_bus}, {8'h0, st_a});
      else       check({req, " bus"}, {8'h0, par_bus}, {8'h0, tb_drv});
      check({req, " par_b"}, {8'h0, par_b}, {8'h0, st_b});
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    m16 = 16'h0;
    pulse(1, 0, 1);
    pulse(1, 0, 0);
    @(negedge clk); rst_n = 1; skip = 2;
  endtask

  initial begin
    logic [7:0] keep;
    logic [15:0] pat;
    // R3: reset state, stages clear while reset is held
    pulse(1, 0, 1);
    pulse(1, 0, 1);
    check("R3 reset ser_out", {15'h0, ser_out}, 16'h0);
    check("R3 reset ser_out_b", {15'h0, ser_out_b}, 16'h0);
    @(negedge clk); oe_n = 0;
    pulse(0, 1, 0);
    check("R3 reset store", {8'h0, par_bus}, 16'h0);
    @(negedge clk); rst_n = 1; skip = 2;

    // R4: two edges after release consumed
    pulse(1, 0, 1);
    pulse(1, 0, 1);
    pulse(0, 1, 0);
    check("R4 consumed edges", {8'h0, par_bus}, 16'h0);
    // R9 and R6: bit order
    pulse(1, 0, 1);
    for (int i = 0; i < 7; i++) pulse(1, 0, 0);
    pulse(0, 1, 0);
    check("R9 order", {8'h0, par_bus}, 16'h0080);
    check("R6 ser_out last stage", {15'h0, ser_out}, 16'h1);
    check_all("R1");

    // R2: shifting without store leaves storage
    keep = par_bus;
    for (int i = 0; i < 3; i++) pulse(1, 0, i[0]);
    check("R2 hold", {8'h0, par_bus}, {8'h0, keep});
    check_all("R2");

    // R7: simultaneous edges
    for (int i = 0; i < 4; i++) pulse(1, 0, 1);
    keep = m16[7:0];
    pulse(1, 1, 0);
    check("R7 same edge", {8'h0, par_bus}, {8'h0, keep});
    check_all("R7");

    // R5 and R6: release and re-drive
    @(negedge clk); tb_drv = ~st_a; oe_n = 1;
    @(negedge clk);
    check("R5 released", {8'h0, par_bus}, {8'h0, tb_drv});
    check("R6 ser_out oe high", {15'h0, ser_out}, {15'h0, m16[7]});
    @(negedge clk); oe_n = 0;
    @(negedge clk);
    check("R5 driven", {8'h0, par_bus}, {8'h0, st_a});

    // R3: reset keeps storage
    keep = st_a;
    @(negedge clk); rst_n = 0; m16 = 16'h0;
    @(negedge clk);
    check("R3 ser_out cleared", {15'h0, ser_out}, 16'h0);
    check("R3 storage kept", {8'h0, par_bus}, {8'h0, keep});
    pulse(1, 0, 1);
    @(negedge clk); rst_n = 1; skip = 2;
    pulse(1, 0, 1);
    pulse(1, 0, 1);
    pulse(1, 0, 1);
    pulse(0, 1, 0);
    check("R4 third edge shifts", {8'h0, par_bus}, 16'h0001);

    // R8: cascade
    pat = 16'hC3A5;
    for (int i = 15; i >= 0; i--) pulse(1, 0, pat[i]);
    pulse(0, 1, 0);
    check("R8 cascade low", {8'h0, par_bus}, {8'h0, pat[7:0]});
    check("R8 cascade high", {8'h0, par_b}, {8'h0, pat[15:8]});

    // random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 9) begin
        @(negedge clk); tb_drv = 8'($urandom); oe_n = ~oe_n;
        @(negedge clk);
      end else if (op == 8) begin
        do_reset();
      end else begin
        pulse(op < 6 || op == 7, op >= 6, 1'($urandom));
      end
      check_all("R1 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule